// File: doc/BRIEF.md
# Binary Hypervector Processing Unit

This block is the arithmetic core for binary hyperdimensional computing. Hypervectors live in a word-organised scratchpad that is split across several banks. Each cycle the unit processes one word of `W` bits. The hypervector length is held in a dimension register that software loads between operations. A single start pulse launches one of six operations over the whole hypervector:

- XOR binding.
- Accumulation into per-bit saturating counters.
- Majority clipping of those counters back into a hypervector.
- Word-granular cyclic rotation.
- Hamming distance.
- Nearest-class search over a group of stored class hypervectors.

A host port writes and reads scratchpad words while the unit is idle. When an operation finishes, the unit raises `done` for one cycle. A command that cannot run sets `err` and leaves every piece of state untouched.

Rotation does not use a wide shifter. Instead, the control block computes the source word address as `(i + s) mod L`, where `L` is the length in words and `s` is the rotation amount. Because this mapping is a bijection, every word is copied exactly once.

Top module: `hv_unit`

## Requirements
- R1: After reset, `busy`, `done`, `err`, `distance` and `bestIdx` are all 0, and every bundling counter is 0.
- R2: The bind operation (`opSel`=0) writes `mem[dst+i] = mem[srcA+i] XOR mem[srcB+i]` for each word i in 0..L-1, where L = `cfgDim`/W.
- R3: The bundle operation (`opSel`=1) updates one signed 3-bit counter per hypervector bit at word `srcA+i`. The counter gains +1 for a 1 bit and -1 for a 0 bit. It saturates at +3 and -3 and never wraps.
- R4: The clip operation (`opSel`=2) writes, for each bit, 1 if its counter is greater than 0 and 0 otherwise (a counter at zero gives 0). It then clears the counters of the words it processed.
- R5: The permute operation (`opSel`=3) writes `mem[dst+i] = mem[srcA+((i+s) mod L)]`, with `s` = `shiftWords`. Amounts of L or more wrap.
- R6: The similarity operation (`opSel`=4) sets `distance` to the number of differing bits between the hypervectors at `srcA` and `srcB`, and sets `bestIdx` to 0.
- R7: The search operation (`opSel`=5) compares the query at `srcA` with `numClasses` class hypervectors. Class m is stored at `srcB+m*L`. The operation sets `bestIdx` to the class with the smallest Hamming distance, breaking ties toward the lower index, and sets `distance` to that minimum.
- R8: A start is rejected if `cfgDim` is 0, not a multiple of W, or above `MAX_WORDS*W`, if the opcode is above 5, or if a search has a class count of 0 or above `MAX_CLASSES`. A rejected start sets `err`, leaves `busy` low, never raises `done` and changes no memory. The next accepted start clears `err`.
- R9: `done` is high for exactly one cycle. It is seen L cycles after the start edge for single-vector operations and L*M cycles after it for a search over M classes.
- R10: While idle, a host write stores `hostWdata` at `hostAddr`. `hostRdata` always shows the word at `hostAddr` combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgWe | input | 1 | Load `cfgDim` into the dimension register (while idle) |
| cfgDim | input | DIM_W | Hypervector length in bits |
| start | input | 1 | Begin the selected operation |
| opSel | input | 3 | Operation code: 0 bind, 1 bundle, 2 clip, 3 permute, 4 similarity, 5 search |
| srcA | input | ADDR_W | First operand or query base word address |
| srcB | input | ADDR_W | Second operand or class table base address |
| dst | input | ADDR_W | Result base address |
| shiftWords | input | WIDX_W | Rotation amount in words |
| numClasses | input | NCLS_W | Number of classes for search |
| hostWe | input | 1 | Host scratchpad write strobe |
| hostAddr | input | ADDR_W | Host word address |
| hostWdata | input | W | Host write data |
| hostRdata | output | W | Word at `hostAddr` |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Last start was rejected |
| distance | output | DIST_W | Hamming distance result |
| bestIdx | output | CLS_W | Winning class index |

## Verification
The bench counts cycles from the start edge. It expects `done` after exactly L such cycles, or L*M for a search, and confirms that `done` drops one cycle later. The scratchpad results, `distance` and `bestIdx` are all registered at the same edge that raises `done`, so they are read in that cycle or later. A rejected start is judged one cycle after its edge: `err` must be high and `busy` low at that point. The destination words are then read back to confirm they are unchanged. All signals are sampled on the falling edge, half a period after the register update.

// File: rtl/hv_pkg.sv
package hv_pkg;

  typedef enum logic [2:0] {
    OP_BIND    = 3'd0,
    OP_BUNDLE  = 3'd1,
    OP_CLIP    = 3'd2,
    OP_PERMUTE = 3'd3,
    OP_SIMILAR = 3'd4,
    OP_SEARCH  = 3'd5
  } hvOpE;

  // strobes from control to datapath, valid for the word being processed
  typedef struct packed {
    logic run;
    logic firstWord;
    logic lastWord;
    logic lastAll;
    hvOpE op;
  } hvStbT;

endpackage

// File: rtl/hv_ctrl.sv
module hv_ctrl
  import hv_pkg::*;
#(
  parameter int W           = 8,
  parameter int ADDR_W      = 6,
  parameter int MAX_WORDS   = 8,
  parameter int MAX_CLASSES = 4,
  parameter int DIM_W       = 7,
  parameter int WIDX_W      = 3,
  parameter int CLS_W       = 2,
  parameter int NCLS_W      = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic [DIM_W-1:0]  cfgDim,
  input  logic              start,
  input  logic [2:0]        opIn,
  input  logic [ADDR_W-1:0] srcA,
  input  logic [ADDR_W-1:0] srcB,
  input  logic [ADDR_W-1:0] dst,
  input  logic [WIDX_W-1:0] shiftIn,
  input  logic [NCLS_W-1:0] numClasses,
  output hvStbT             stb,
  output logic [ADDR_W-1:0] addrA,
  output logic [ADDR_W-1:0] addrB,
  output logic [ADDR_W-1:0] addrD,
  output logic [WIDX_W-1:0] wordIdx,
  output logic [CLS_W-1:0]  classIdx,
  output logic              busy,
  output logic              done,
  output logic              err
);
  localparam int LOG_W = $clog2(W);
  localparam int LEN_W = WIDX_W + 1;

  logic [DIM_W-1:0]  dimQ;
  logic              busyQ, doneQ, errQ;
  hvOpE              opQ;
  logic [ADDR_W-1:0] aBaseQ, bBaseQ, dBaseQ;
  logic [LEN_W-1:0]  lenQ, shiftQ;
  logic [NCLS_W-1:0] nclsQ;
  logic [WIDX_W-1:0] wordQ;
  logic [CLS_W-1:0]  clsQ;

  logic [LEN_W-1:0]  lenCalc, shiftCalc;
  logic              dimOk, opOk, clsOk, cmdOk;
  logic              lastWord, lastAll;
  logic [LEN_W:0]    sumIdx, rotIdx;

  always_comb begin
    lenCalc   = LEN_W'(dimQ >> LOG_W);
    dimOk     = (dimQ != '0) && (dimQ[LOG_W-1:0] == '0) && (int'(dimQ) <= MAX_WORDS * W);
    opOk      = (opIn <= 3'(OP_SEARCH));
    clsOk     = (opIn != 3'(OP_SEARCH)) ||
                ((numClasses != '0) && (int'(numClasses) <= MAX_CLASSES));
    cmdOk     = dimOk && opOk && clsOk;
    shiftCalc = (lenCalc == '0) ? '0 : LEN_W'(LEN_W'(shiftIn) % lenCalc);
  end

  always_comb begin
    lastWord = ({1'b0, wordQ} == lenQ - LEN_W'(1));
    lastAll  = lastWord && ((opQ != OP_SEARCH) ||
               ({1'b0, clsQ} == CLS_W'(nclsQ - NCLS_W'(1))) ||
               (NCLS_W'(clsQ) == nclsQ - NCLS_W'(1)));
    sumIdx   = (LEN_W+1)'(wordQ) + (LEN_W+1)'(shiftQ);
    rotIdx   = (sumIdx >= (LEN_W+1)'(lenQ)) ? sumIdx - (LEN_W+1)'(lenQ) : sumIdx;
    addrA    = aBaseQ + ((opQ == OP_PERMUTE) ? ADDR_W'(rotIdx) : ADDR_W'(wordQ));
    addrB    = bBaseQ + ADDR_W'(ADDR_W'(clsQ) * ADDR_W'(lenQ)) + ADDR_W'(wordQ);
    addrD    = dBaseQ + ADDR_W'(wordQ);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dimQ   <= '0;
      busyQ  <= 1'b0;
      doneQ  <= 1'b0;
      errQ   <= 1'b0;
      opQ    <= OP_BIND;
      aBaseQ <= '0;
      bBaseQ <= '0;
      dBaseQ <= '0;
      lenQ   <= '0;
      shiftQ <= '0;
      nclsQ  <= '0;
      wordQ  <= '0;
      clsQ   <= '0;
    end else begin
      doneQ <= 1'b0;
      if (cfgWe && !busyQ) dimQ <= cfgDim;
      if (!busyQ) begin
        if (start) begin
          if (cmdOk) begin
            busyQ  <= 1'b1;
            errQ   <= 1'b0;
            opQ    <= hvOpE'(opIn);
            aBaseQ <= srcA;
            bBaseQ <= srcB;
            dBaseQ <= dst;
            lenQ   <= lenCalc;
            shiftQ <= shiftCalc;
            nclsQ  <= numClasses;
            wordQ  <= '0;
            clsQ   <= '0;
          end else begin
            errQ <= 1'b1;
          end
        end
      end else if (lastWord) begin
        if (lastAll) begin
          busyQ <= 1'b0;
          doneQ <= 1'b1;
        end else begin
          wordQ <= '0;
          clsQ  <= clsQ + CLS_W'(1);
        end
      end else begin
        wordQ <= wordQ + WIDX_W'(1);
      end
    end
  end

  assign stb.run       = busyQ;
  assign stb.firstWord = (wordQ == '0);
  assign stb.lastWord  = lastWord;
  assign stb.lastAll   = lastAll;
  assign stb.op        = opQ;
  assign wordIdx       = wordQ;
  assign classIdx      = clsQ;
  assign busy          = busyQ;
  assign done          = doneQ;
  assign err           = errQ;

endmodule

// File: rtl/hv_datapath.sv
module hv_datapath
  import hv_pkg::*;
#(
  parameter int W          = 8,
  parameter int NUM_BANKS  = 4,
  parameter int BANK_DEPTH = 16,
  parameter int ADDR_W     = 6,
  parameter int MAX_WORDS  = 8,
  parameter int CNT_W      = 3,
  parameter int WIDX_W     = 3,
  parameter int CLS_W      = 2,
  parameter int DIST_W     = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  hvStbT             stb,
  input  logic [ADDR_W-1:0] addrA,
  input  logic [ADDR_W-1:0] addrB,
  input  logic [ADDR_W-1:0] addrD,
  input  logic [WIDX_W-1:0] wordIdx,
  input  logic [CLS_W-1:0]  classIdx,
  input  logic              hostWe,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [W-1:0]      hostWdata,
  output logic [W-1:0]      hostRdata,
  output logic [DIST_W-1:0] distance,
  output logic [CLS_W-1:0]  bestIdx
);
  localparam int BANK_W = $clog2(NUM_BANKS);
  localparam int NCNT   = MAX_WORDS * W;
  localparam logic signed [CNT_W-1:0] CNT_MAX = CNT_W'((1 << (CNT_W - 1)) - 1);
  localparam logic signed [CNT_W-1:0] CNT_MIN = -CNT_MAX;

  logic [W-1:0] rdA [NUM_BANKS];
  logic [W-1:0] rdB [NUM_BANKS];
  logic [W-1:0] rdH [NUM_BANKS];
  logic [W-1:0] wordA, wordB, clipWord, wrData;
  logic [ADDR_W-1:0] wrAddr;
  logic         wrEn;

  logic signed [CNT_W-1:0] cntQ [NCNT];
  logic [DIST_W-1:0] accQ, distQ, popCnt, partial;
  logic [CLS_W-1:0]  bestQ;

  // banked scratchpad: low address bits pick the bank
  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic [W-1:0] rows [BANK_DEPTH];
    always_ff @(posedge clk) begin
      if (wrEn && (wrAddr[BANK_W-1:0] == BANK_W'(b)))
        rows[wrAddr[ADDR_W-1:BANK_W]] <= wrData;
    end
    assign rdA[b] = rows[addrA[ADDR_W-1:BANK_W]];
    assign rdB[b] = rows[addrB[ADDR_W-1:BANK_W]];
    assign rdH[b] = rows[hostAddr[ADDR_W-1:BANK_W]];
  end

  assign wordA     = rdA[addrA[BANK_W-1:0]];
  assign wordB     = rdB[addrB[BANK_W-1:0]];
  assign hostRdata = rdH[hostAddr[BANK_W-1:0]];

  function automatic logic signed [CNT_W-1:0] satStep(
    input logic signed [CNT_W-1:0] c, input logic up);
    if (up) return (c == CNT_MAX) ? c : c + CNT_W'(1);
    return (c == CNT_MIN) ? c : c - CNT_W'(1);
  endfunction

  always_comb begin
    clipWord = '0;
    for (int w = 0; w < MAX_WORDS; w++)
      if (wordIdx == WIDX_W'(w))
        for (int j = 0; j < W; j++)
          clipWord[j] = (cntQ[w*W+j] > 0);
  end

  always_comb begin
    wrEn   = 1'b0;
    wrAddr = hostAddr;
    wrData = hostWdata;
    if (stb.run) begin
      wrAddr = addrD;
      unique case (stb.op)
        OP_BIND:    begin wrEn = 1'b1; wrData = wordA ^ wordB; end
        OP_PERMUTE: begin wrEn = 1'b1; wrData = wordA;         end
        OP_CLIP:    begin wrEn = 1'b1; wrData = clipWord;      end
        default:    wrEn = 1'b0;
      endcase
    end else begin
      wrEn = hostWe;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NCNT; i++) cntQ[i] <= '0;
    end else if (stb.run && (stb.op == OP_BUNDLE || stb.op == OP_CLIP)) begin
      for (int w = 0; w < MAX_WORDS; w++)
        if (wordIdx == WIDX_W'(w))
          for (int j = 0; j < W; j++)
            cntQ[w*W+j] <= (stb.op == OP_CLIP) ? '0 : satStep(cntQ[w*W+j], wordA[j]);
    end
  end

  always_comb begin
    popCnt  = DIST_W'($countones(wordA ^ wordB));
    partial = (stb.firstWord ? '0 : accQ) + popCnt;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      accQ  <= '0;
      distQ <= '0;
      bestQ <= '0;
    end else if (stb.run && (stb.op == OP_SIMILAR || stb.op == OP_SEARCH)) begin
      accQ <= partial;
      if (stb.lastWord) begin
        if (stb.op == OP_SIMILAR) begin
          distQ <= partial;
          bestQ <= '0;
        end else if (classIdx == '0 || partial < distQ) begin
          distQ <= partial;
          bestQ <= classIdx;
        end
      end
    end
  end

  assign distance = distQ;
  assign bestIdx  = bestQ;

endmodule

// File: rtl/hv_unit.sv
module hv_unit
  import hv_pkg::*;
#(
  parameter int W           = 8,
  parameter int NUM_BANKS   = 4,
  parameter int BANK_DEPTH  = 16,
  parameter int MAX_WORDS   = 8,
  parameter int MAX_CLASSES = 4,
  parameter int CNT_W       = 3,
  localparam int ADDR_W     = $clog2(NUM_BANKS * BANK_DEPTH),
  localparam int DIM_W      = $clog2(MAX_WORDS * W + 1),
  localparam int WIDX_W     = $clog2(MAX_WORDS),
  localparam int CLS_W      = $clog2(MAX_CLASSES),
  localparam int NCLS_W     = $clog2(MAX_CLASSES + 1),
  localparam int DIST_W     = $clog2(MAX_WORDS * W + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic [DIM_W-1:0]  cfgDim,
  input  logic              start,
  input  logic [2:0]        opSel,
  input  logic [ADDR_W-1:0] srcA,
  input  logic [ADDR_W-1:0] srcB,
  input  logic [ADDR_W-1:0] dst,
  input  logic [WIDX_W-1:0] shiftWords,
  input  logic [NCLS_W-1:0] numClasses,
  input  logic              hostWe,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [W-1:0]      hostWdata,
  output logic [W-1:0]      hostRdata,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic [DIST_W-1:0] distance,
  output logic [CLS_W-1:0]  bestIdx
);
  hvStbT             stb;
  logic [ADDR_W-1:0] addrA, addrB, addrD;
  logic [WIDX_W-1:0] wordIdx;
  logic [CLS_W-1:0]  classIdx;

  hv_ctrl #(
    .W(W), .ADDR_W(ADDR_W), .MAX_WORDS(MAX_WORDS), .MAX_CLASSES(MAX_CLASSES),
    .DIM_W(DIM_W), .WIDX_W(WIDX_W), .CLS_W(CLS_W), .NCLS_W(NCLS_W)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgDim(cfgDim), .start(start),
    .opIn(opSel), .srcA(srcA), .srcB(srcB), .dst(dst), .shiftIn(shiftWords),
    .numClasses(numClasses), .stb(stb), .addrA(addrA), .addrB(addrB),
    .addrD(addrD), .wordIdx(wordIdx), .classIdx(classIdx), .busy(busy),
    .done(done), .err(err)
  );

  hv_datapath #(
    .W(W), .NUM_BANKS(NUM_BANKS), .BANK_DEPTH(BANK_DEPTH), .ADDR_W(ADDR_W),
    .MAX_WORDS(MAX_WORDS), .CNT_W(CNT_W), .WIDX_W(WIDX_W), .CLS_W(CLS_W),
    .DIST_W(DIST_W)
  ) dp_i (
    .clk(clk), .rstN(rstN), .stb(stb), .addrA(addrA), .addrB(addrB),
    .addrD(addrD), .wordIdx(wordIdx), .classIdx(classIdx), .hostWe(hostWe),
    .hostAddr(hostAddr), .hostWdata(hostWdata), .hostRdata(hostRdata),
    .distance(distance), .bestIdx(bestIdx)
  );

endmodule

// File: rtl/hv_unit_chk.sv
module hv_unit_chk #(
  parameter int DIST_W  = 7,
  parameter int MAX_DIM = 64
) (
  input logic              clk,
  input logic              rstN,
  input logic              start,
  input logic              busy,
  input logic              done,
  input logic              err,
  input logic [DIST_W-1:0] distance
);
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R9

  AST_DONE_ENDS_RUN: assert property (@(posedge clk) disable iff (!rstN)
    $rose(done) |-> $past(busy) && !busy); // R9

  AST_ERR_NOT_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    !(err && busy)); // R8

  AST_ERR_NO_DONE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(err) |-> !done && !busy); // R8

  AST_DIST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !start) |=> $stable(distance)); // R6

  AST_DIST_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    int'(distance) <= MAX_DIM); // R7
endmodule

bind hv_unit hv_unit_chk #(.DIST_W(DIST_W), .MAX_DIM(MAX_WORDS * W)) chk_i (
  .clk(clk), .rstN(rstN), .start(start), .busy(busy), .done(done),
  .err(err), .distance(distance)
);

// File: tb/hv_unit_tb_top.sv
`timescale 1ns/1ps
module hv_unit_tb_top;
  localparam int CMAX = 3;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       cfgWe = 1'b0;
  logic [6:0] cfgDim = '0;
  logic       start = 1'b0;
  logic [2:0] opSel = '0;
  logic [5:0] srcA = '0, srcB = '0, dst = '0;
  logic [2:0] shiftWords = '0;
  logic [2:0] numClasses = '0;
  logic       hostWe = 1'b0;
  logic [5:0] hostAddr = '0;
  logic [7:0] hostWdata = '0;
  logic [7:0] hostRdata;
  logic       busy, done, err;
  logic [6:0] distance;
  logic [1:0] bestIdx;

  int checks = 0;
  int errors = 0;
  logic [7:0] memM [64];
  int cntM [64];

  always #2.5 clk = ~clk;

  hv_unit dut_i (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgDim(cfgDim), .start(start),
    .opSel(opSel), .srcA(srcA), .srcB(srcB), .dst(dst), .shiftWords(shiftWords),
    .numClasses(numClasses), .hostWe(hostWe), .hostAddr(hostAddr),
    .hostWdata(hostWdata), .hostRdata(hostRdata), .busy(busy), .done(done),
    .err(err), .distance(distance), .bestIdx(bestIdx)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic hostWrite(input int a, input logic [7:0] d);
    @(negedge clk);
    hostWe = 1'b1; hostAddr = 6'(a); hostWdata = d;
    @(negedge clk);
    hostWe = 1'b0;
    memM[a] = d;
  endtask

  task automatic hostRead(input int a, output logic [7:0] d);
    @(negedge clk);
    hostAddr = 6'(a);
    #1 d = hostRdata;
  endtask

  task automatic setDim(input int d);
    @(negedge clk);
    cfgWe = 1'b1; cfgDim = 7'(d);
    @(negedge clk);
    cfgWe = 1'b0;
  endtask

  task automatic pulseStart(input int op, input int a, input int b, input int d,
                            input int s, input int m);
    @(negedge clk);
    opSel = 3'(op); srcA = 6'(a); srcB = 6'(b); dst = 6'(d);
    shiftWords = 3'(s); numClasses = 3'(m); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  // R9: done after expCyc cycles from the start edge, one cycle wide
  task automatic runOp(input int op, input int a, input int b, input int d,
                       input int s, input int m, input int expCyc);
    int cyc;
    pulseStart(op, a, b, d, s, m);
    cyc = 0;
    while (!done && cyc < 400) begin
      @(negedge clk);
      cyc++;
    end
    check(cyc == expCyc, "R9 done latency", cyc, expCyc);
    @(negedge clk);
    check(done == 1'b0, "R9 done single cycle", int'(done), 0);
  endtask

  task automatic checkRegion(input int base, input int len, input string req);
    logic [7:0] d;
    for (int i = 0; i < len; i++) begin
      hostRead(base + i, d);
      check(d == memM[base + i], req, int'(d), int'(memM[base + i]));
    end
  endtask

  function automatic int hamming(input int a, input int b, input int len);
    int h = 0;
    for (int i = 0; i < len; i++) h += $countones(memM[a + i] ^ memM[b + i]);
    return h;
  endfunction

  task automatic doBind(input int len);
    runOp(0, 0, 8, 16, 0, 0, len);
    for (int i = 0; i < len; i++) memM[16 + i] = memM[i] ^ memM[8 + i];
    checkRegion(16, len, "R2 bind xor");
  endtask

  task automatic doBundle(input int a, input int len);
    runOp(1, a, 0, 0, 0, 0, len);
    for (int i = 0; i < len; i++)
      for (int j = 0; j < 8; j++) begin
        int k = i * 8 + j;
        if (memM[a + i][j]) cntM[k] = (cntM[k] == CMAX) ? CMAX : cntM[k] + 1;
        else                cntM[k] = (cntM[k] == -CMAX) ? -CMAX : cntM[k] - 1;
      end
  endtask

  task automatic doClip(input int len, input string req);
    runOp(2, 0, 0, 16, 0, 0, len);
    for (int i = 0; i < len; i++)
      for (int j = 0; j < 8; j++) begin
        memM[16 + i][j] = (cntM[i * 8 + j] > 0);
        cntM[i * 8 + j] = 0;
      end
    checkRegion(16, len, req);
  endtask

  task automatic doPermute(input int len, input int s);
    logic [7:0] src [8];
    runOp(3, 0, 0, 16, s, 0, len);
    for (int i = 0; i < len; i++) src[i] = memM[i];
    for (int i = 0; i < len; i++) memM[16 + i] = src[(i + s) % len];
    checkRegion(16, len, "R5 permute rotation");
  endtask

  task automatic doSimilar(input int len);
    int h = hamming(0, 8, len);
    runOp(4, 0, 8, 0, 0, 0, len);
    check(int'(distance) == h, "R6 hamming distance", int'(distance), h);
    check(bestIdx == 2'd0, "R6 index cleared", int'(bestIdx), 0);
  endtask

  task automatic doSearch(input int len, input int m);
    int best = 0;
    int bd = hamming(0, 32, len);
    for (int c = 1; c < m; c++) begin
      int h = hamming(0, 32 + c * len, len);
      if (h < bd) begin bd = h; best = c; end
    end
    runOp(5, 0, 32, 0, 0, m, len * m);
    check(int'(bestIdx) == best, "R7 search index", int'(bestIdx), best);
    check(int'(distance) == bd, "R7 search distance", int'(distance), bd);
  endtask

  task automatic tryBad(input int op, input int m, input string req);
    pulseStart(op, 0, 8, 16, 0, m);
    check(err == 1'b1, {req, " err set"}, int'(err), 1);
    check(busy == 1'b0, {req, " not busy"}, int'(busy), 0);
    repeat (3) begin
      @(negedge clk);
      check(done == 1'b0, {req, " no done"}, int'(done), 0);
    end
  endtask

  initial begin
    #(5.0 * 150000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(20250417));
    for (int i = 0; i < 64; i++) cntM[i] = 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(busy == 0 && done == 0 && err == 0, "R1 reset flags",
          int'({busy, done, err}), 0);
    check(distance == 0 && bestIdx == 0, "R1 reset results",
          int'(distance) + int'(bestIdx), 0);
    rstN = 1'b1;

    // R10 host access over the whole scratchpad
    for (int i = 0; i < 64; i++) hostWrite(i, 8'($urandom));
    checkRegion(0, 64, "R10 host readback");

    // R1 counters are zero after reset: clip gives all zeros
    setDim(64);
    doClip(8, "R1 counters reset");

    doBind(8);
    setDim(24);
    doBind(3);

    // R3 saturation: five +1 then four -1 leaves -1 if saturated (clip 0)
    for (int i = 0; i < 8; i++) hostWrite(i, 8'hFF);
    for (int i = 0; i < 8; i++) hostWrite(8 + i, 8'h00);
    setDim(64);
    repeat (5) doBundle(0, 8);
    repeat (4) doBundle(8, 8);
    doClip(8, "R3 saturating counters");
    // R4 zero counter clips to 0, positive clips to 1
    hostWrite(0, 8'hF0); hostWrite(8, 8'h3C);
    setDim(8);
    doBundle(0, 1); doBundle(8, 1);
    doClip(1, "R4 tie gives zero");
    doBundle(0, 1); doBundle(0, 1); doBundle(8, 1);
    doClip(1, "R4 majority");
    doClip(1, "R4 clip clears counters");

    // R5 rotation, including an amount at or above the length
    for (int i = 0; i < 8; i++) hostWrite(i, 8'(i * 17 + 1));
    setDim(64);
    doPermute(8, 3);
    setDim(32);
    doPermute(4, 6);
    doPermute(4, 0);

    // R6 identical and complementary operands
    setDim(64);
    for (int i = 0; i < 8; i++) hostWrite(8 + i, memM[i]);
    doSimilar(8);
    for (int i = 0; i < 8; i++) hostWrite(8 + i, ~memM[i]);
    doSimilar(8);

    // R7 tie goes to the lower index
    setDim(16);
    for (int i = 0; i < 2; i++) begin
      hostWrite(32 + i, ~memM[i]);
      hostWrite(34 + i, memM[i] ^ 8'h01);
      hostWrite(36 + i, memM[i] ^ 8'h01);
      hostWrite(38 + i, memM[i] ^ 8'h03);
    end
    doSearch(2, 4);
    for (int i = 0; i < 2; i++) begin
      hostWrite(32 + i, memM[i] ^ 8'h10);
      hostWrite(34 + i, memM[i] ^ 8'h10);
    end
    doSearch(2, 2);

    // R8 rejected commands
    setDim(12); tryBad(0, 0, "R8 dim not multiple");
    setDim(0);  tryBad(4, 0, "R8 dim zero");
    setDim(72); tryBad(0, 0, "R8 dim too large");
    setDim(16); tryBad(6, 0, "R8 bad opcode");
    tryBad(5, 0, "R8 zero classes");
    tryBad(5, 5, "R8 too many classes");
    checkRegion(16, 8, "R8 memory untouched");
    doBind(2);
    check(err == 1'b0, "R8 err cleared by accepted start", int'(err), 0);

    // random mix
    for (int it = 0; it < 40; it++) begin
      int len = 1 + int'($urandom % 8);
      int op = int'($urandom % 5);
      setDim(len * 8);
      for (int i = 0; i < len; i++) begin
        hostWrite(i, 8'($urandom));
        hostWrite(8 + i, 8'($urandom));
      end
      case (op)
        0: doBind(len);
        1: begin doBundle(0, len); doBundle(8, len); doBundle(0, len); doClip(len, "R3 R4 random"); end
        2: doPermute(len, int'($urandom % 8));
        3: doSimilar(len);
        default: begin
          int m = 1 + int'($urandom % 4);
          for (int i = 0; i < len * m; i++) hostWrite(32 + i, 8'($urandom));
          doSearch(len, m);
        end
      endcase
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule